// File: doc/BRIEF.md
# Busy Status Polling Responder

This block shapes the word returned on a memory read bus while the memory runs an internal program or erase operation. A host that has just loaded a word can learn that the operation has ended in two ways. It can watch the top bit of each byte lane, which reads inverted against the word it loaded until the operation completes. It can also watch bit 6 and bit 14, which change value on every new read while the operation runs and stop changing once it is done. When the memory is not busy, the stored array word passes through unchanged.

A new read begins on the rising edge of the combined read strobe, which is chip select AND output enable, both active high. Either signal may be pulsed while the other is held, or both may be pulsed together. The returned word and the bus-drive flag are registered, so the read bus shows the result one clock after the strobe inputs are sampled. The busy flag, the last loaded word and its address come from the write controller. The programming timer itself lives outside this block.

Top module: `busy_status_responder`

## Requirements
- R1: While reset is high, and on the first edge after it, `rd_drive` is 0 and `rd_data` is 0.
- R2: `rd_drive` goes to 1 one clock after `chip_sel` and `out_en` are both sampled high, and to 0 otherwise. While it is 0, `rd_data` is 0.
- R3: When a read is sampled with `busy` low, `rd_data` one clock later equals `array_data` in all 16 bits, including bits 6, 7, 14 and 15.
- R4: When a read is sampled with `busy` high, `rd_data` bit 7 and bit 15 equal the complement of `last_word` bit 7 and bit 15.
- R5: During `busy`, each new read returns bit 6 and bit 14 opposite to the values of the previous busy read. Within one read, bit 6 and bit 14 are equal. Their first value is not defined.
- R6: The toggle state advances only on a rising edge of the read strobe while `busy` is high. While a read is held over several clocks, bits 6 and 14 do not change.
- R7: A new read is recognised when `out_en` pulses while `chip_sel` is held, when `chip_sel` pulses while `out_en` is held, or when both pulse together.
- R8: During `busy`, the bits other than 6, 7, 14 and 15 return `array_data`. They return 0 instead when `rd_addr` equals `last_addr`.
- R9: Once `busy` falls, bits 7 and 15 return true array data, and bits 6 and 14 stop changing between reads.
- R10: The inverted top bits and the toggling bits both appear in the same returned word during a busy read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| busy | input | 1 | Internal program or erase in progress |
| last_word | input | 16 | Last word loaded by the host |
| last_addr | input | 16 | Address of the last loaded word |
| rd_addr | input | 16 | Address of the current read |
| array_data | input | 16 | Word read from the array |
| rd_data | output | 16 | Returned read word (0 when not driven) |
| rd_drive | output | 1 | Read bus drive enable |

## Verification
Data polling and the toggle bit act on the same busy read. Both show in one returned word, and the toggle state may advance in the same clock that the inverted top bits are presented. The bench provokes this with back-to-back busy reads that use different last-word values and address hits, starting each read by pulsing output enable, chip select, or both. The scoreboard checks the exact complement of the top bits and the exact pass-through or zeroing of the other bits on every read. It does not know the starting value of the toggle, so it learns that value from the first busy read and then judges each later read by alternation relative to the previous one.

// File: rtl/busy_poll_pkg.sv
package busy_poll_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 2;
  localparam int DATA_W  = LANE_W * LANES;
  localparam int POLL_BIT = LANE_W - 1;
  localparam int TOG_BIT  = LANE_W - 2;

  typedef enum logic [1:0] {
    RD_RELEASE = 2'd0,
    RD_PASS    = 2'd1,
    RD_STATUS  = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/bpr_strobe_edge.sv
module bpr_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic chip_sel,
  input  logic out_en,
  output logic strobe,
  output logic rise
);
  logic strobe_q;

  assign strobe = chip_sel & out_en;
  assign rise   = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (rst) rise |=> !rise); // R7
endmodule

// File: rtl/bpr_toggle.sv
module bpr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic busy,
  output logic tog_next
);
  logic tog_q;

  assign tog_next = tog_q ^ (rise & busy);

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_next;
  end

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst) (rise && busy) |=> (tog_q != $past(tog_q))); // R5
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst) !(rise && busy) |=> $stable(tog_q)); // R6
endmodule

// File: rtl/bpr_lane_merge.sv
module bpr_lane_merge
  import busy_poll_pkg::*;
#(
  parameter int W    = LANE_W,
  parameter int PBIT = POLL_BIT,
  parameter int TBIT = TOG_BIT
) (
  input  rd_mode_e       mode,
  input  logic [W-1:0]   arr_lane,
  input  logic [W-1:0]   last_lane,
  input  logic           tog,
  input  logic           hit,
  output logic [W-1:0]   out_lane
);
  logic [W-1:0] base;

  always_comb begin
    base = hit ? '0 : arr_lane;
    base[PBIT] = ~last_lane[PBIT];
    base[TBIT] = tog;
    case (mode)
      RD_PASS:   out_lane = arr_lane;
      RD_STATUS: out_lane = base;
      default:   out_lane = '0;
    endcase
  end
endmodule

// File: rtl/busy_status_responder.sv
module busy_status_responder
  import busy_poll_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel,
  input  logic              out_en,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_word,
  input  logic [AW-1:0]     last_addr,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  logic strobe, rise, tog_next, hit;
  rd_mode_e mode;
  logic [DATA_W-1:0] merged;

  bpr_strobe_edge u_edge (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .out_en(out_en),
    .strobe(strobe), .rise(rise)
  );

  bpr_toggle u_tog (
    .clk(clk), .rst(rst), .rise(rise), .busy(busy), .tog_next(tog_next)
  );

  assign hit = (rd_addr == last_addr);

  always_comb begin
    if (!strobe)   mode = RD_RELEASE;
    else if (busy) mode = RD_STATUS;
    else           mode = RD_PASS;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bpr_lane_merge #(.W(LANE_W), .PBIT(POLL_BIT), .TBIT(TOG_BIT)) u_merge (
      .mode(mode),
      .arr_lane(array_data[g*LANE_W +: LANE_W]),
      .last_lane(last_word[g*LANE_W +: LANE_W]),
      .tog(tog_next),
      .hit(hit),
      .out_lane(merged[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_data  <= merged;
      rd_drive <= strobe;
    end
  end

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst) !(chip_sel && out_en) |=> (!rd_drive && rd_data == '0)); // R2
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst) (chip_sel && out_en && !busy) |=> (rd_data == $past(array_data))); // R3
  AST_POLL_INV: assert property (@(posedge clk) disable iff (rst) (chip_sel && out_en && busy) |=> (rd_data[POLL_BIT] == !$past(last_word[POLL_BIT]) && rd_data[DATA_W-1] == !$past(last_word[DATA_W-1]))); // R4
  AST_TOG_PAIR: assert property (@(posedge clk) disable iff (rst) (chip_sel && out_en && busy) |=> (rd_data[TOG_BIT] == rd_data[LANE_W+TOG_BIT])); // R5
endmodule

// File: tb/busy_status_responder_tb.sv
`timescale 1ns/1ps
module busy_status_responder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_sel = 1'b0, out_en = 1'b0, busy = 1'b0;
  logic [15:0] last_word = '0, last_addr = '0, rd_addr = '0, array_data = '0;
  logic [15:0] rd_data;
  logic rd_drive;

  always #5 clk = ~clk;

  busy_status_responder u_dut (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .out_en(out_en), .busy(busy),
    .last_word(last_word), .last_addr(last_addr), .rd_addr(rd_addr),
    .array_data(array_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  // tmode: 0 exact, 1 first toggle (learn), 2 toggle opposite, 3 toggle same
  typedef struct {
    logic [15:0] data;
    logic        drv;
    int          tmode;
    string       tag;
  } item_t;

  item_t sb[$];
  int vectors = 0, errors = 0;
  logic last_tog = 1'b0;
  bit done = 0;

  function automatic logic [15:0] status_word(input logic [15:0] arr, input logic [15:0] lw, input bit hit);
    logic [15:0] w;
    w = hit ? 16'h0000 : arr;
    w[7]  = ~lw[7];
    w[15] = ~lw[15];
    w[6]  = 1'b0;
    w[14] = 1'b0;
    return w;
  endfunction

  task automatic cyc(input logic r, input logic cs, input logic oe, input logic bz,
                     input logic [15:0] arr, input logic [15:0] lw,
                     input logic [15:0] ra, input logic [15:0] la,
                     input int tm, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; chip_sel = cs; out_en = oe; busy = bz;
    array_data = arr; last_word = lw; rd_addr = ra; last_addr = la;
    it.drv = !r && cs && oe;
    if (!it.drv) it.data = 16'h0000;
    else if (!bz) it.data = arr;
    else it.data = status_word(arr, lw, ra == la);
    it.tmode = it.drv ? tm : 0;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [15:0] mask;
        bit bad;
        it = sb.pop_front();
        vectors++;
        mask = (it.tmode == 0) ? 16'hFFFF : 16'hBFBF;
        bad = ((rd_data & mask) != (it.data & mask)) || (rd_drive != it.drv);
        if (it.tmode != 0 && rd_data[6] != rd_data[14]) bad = 1;
        if (it.tmode == 2 && rd_data[6] != ~last_tog) bad = 1;
        if (it.tmode == 3 && rd_data[6] != last_tog) bad = 1;
        if (bad) begin
          errors++;
          $display("FAIL %s: act data=%h drv=%b tog=%b exp data=%h drv=%b mode=%0d prev_tog=%b",
                   it.tag, rd_data, rd_drive, rd_data[6], it.data, it.drv, it.tmode, last_tog);
        end
        if (it.tmode != 0) last_tog = rd_data[6];
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state, even with a read requested
    cyc(1, 1, 1, 1, 16'hFFFF, 16'h0000, 16'h1, 16'h2, 0, "R1 reset");
    cyc(1, 0, 0, 0, 16'h0000, 16'h0000, 16'h0, 16'h0, 0, "R1 reset");
    // R2 released bus
    cyc(0, 0, 0, 0, 16'hA5A5, 16'h0, 16'h0, 16'h1, 0, "R2 idle release");
    cyc(0, 1, 0, 0, 16'hA5A5, 16'h0, 16'h0, 16'h1, 0, "R2 cs only");
    cyc(0, 0, 1, 0, 16'hA5A5, 16'h0, 16'h0, 16'h1, 0, "R2 oe only");
    // R3 pass-through when idle
    cyc(0, 1, 1, 0, 16'h1234, 16'hFFFF, 16'h5, 16'h5, 0, "R3 pass");
    cyc(0, 1, 1, 0, 16'hC0C0, 16'h0000, 16'h5, 16'h5, 0, "R3 pass held");
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R2 release");
    // busy reads: R4, R5, R8, R10 with pulses of both signals
    cyc(0, 1, 1, 1, 16'h1234, 16'h8001, 16'h10, 16'h20, 1, "R4 R8 R10 first busy read");
    cyc(0, 1, 1, 1, 16'h1234, 16'h8001, 16'h10, 16'h20, 3, "R6 held read");
    cyc(0, 1, 1, 1, 16'h5678, 16'h8001, 16'h10, 16'h20, 3, "R6 held read");
    cyc(0, 0, 0, 1, 16'h0, 16'h8001, 16'h10, 16'h20, 0, "R2 busy release");
    // R7 oe pulse, cs held
    cyc(0, 1, 1, 1, 16'hFFFF, 16'h0080, 16'h20, 16'h20, 2, "R7 R8 oe pulse hit");
    cyc(0, 1, 0, 1, 16'h0, 16'h0080, 16'h20, 16'h20, 0, "R2 oe low");
    cyc(0, 1, 1, 1, 16'hFFFF, 16'h7F7F, 16'h21, 16'h20, 2, "R5 R7 oe pulse");
    // R7 cs pulse, oe held
    cyc(0, 0, 1, 1, 16'h0, 16'h7F7F, 16'h21, 16'h20, 0, "R2 cs low");
    cyc(0, 1, 1, 1, 16'h0F0F, 16'h8080, 16'h22, 16'h20, 2, "R7 R10 cs pulse");
    cyc(0, 0, 1, 1, 16'h0, 16'h8080, 16'h22, 16'h20, 0, "R2 cs low");
    cyc(0, 1, 1, 1, 16'hFFFF, 16'h0000, 16'h22, 16'h22, 2, "R4 R8 cs pulse hit");
    // R6: idle cycles with busy do not advance the toggle
    cyc(0, 0, 0, 1, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R6 gap");
    cyc(0, 0, 0, 1, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R6 gap");
    cyc(0, 1, 1, 1, 16'h4242, 16'h0101, 16'h3, 16'h4, 2, "R5 R6 after gap");
    cyc(0, 0, 0, 1, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R2 release");
    // R9 busy finished: true data, no toggling
    cyc(0, 1, 1, 0, 16'hC0C0, 16'h0000, 16'h4, 16'h4, 0, "R9 done read");
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R2 release");
    cyc(0, 1, 1, 0, 16'hC0C0, 16'h0000, 16'h4, 16'h4, 0, "R9 no toggle");
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R2 release");
    cyc(0, 1, 1, 0, 16'h3F3F, 16'hFFFF, 16'h4, 16'h4, 0, "R9 R3 true top bits");
    // busy again: toggle resumes alternation from held value
    cyc(0, 0, 0, 1, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R2 release");
    cyc(0, 1, 1, 1, 16'h9999, 16'h1111, 16'h8, 16'h9, 2, "R5 R10 resume");
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 16'h0, 16'h1, 0, "R2 release");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule